// File: doc/BRIEF.md
# Paged DMA Channel Address Engine

This block is the transfer engine of a single DMA channel. It keeps a 16-bit current address, a 16-bit current count and a page register that stays fixed. Each acknowledged transfer presents a wide physical address built from the page and the current address. After the transfer the address steps up by one and the count steps down by one. The count is stored as the number of transfers minus one. When it runs out, the engine pulses terminal count. It then either reloads its start values or masks itself.

A parameter fixes the transfer unit for each instance. In byte units the page supplies the address bits above the 16-bit counter, and the channel reaches a 64K window. In word units the counter moves up one bit position, so each count unit is one 16-bit word. Page bit 0 takes no part and the window becomes 128K. The page is never advanced, so a block that runs past the top of its window wraps to the bottom of the same window. The surrounding controller writes the start values through a one-cycle load strobe and sets or clears the channel mask.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is masked, `xfer_valid` and `tc` are low, and `residue` reads 1 (stored count 0).
- R2: No transfer occurs in a cycle where the channel is masked, `req` is low, `ack` is low, or `cfg_load` is high. `xfer_valid` stays low and the presented address and residue do not change.
- R3: In byte units (`UNIT` = 0), `phys_addr` equals {page[7:0], address[15:0]}.
- R4: In word units (`UNIT` = 1), `phys_addr` equals {page[7:1], address[15:0], 1'b0}. Page bit 0 is ignored and bit 0 of the output is always 0.
- R5: Each transfer raises the address by one. From 0xFFFF it wraps to 0x0000 and the page keeps its value.
- R6: Each transfer lowers the stored count by one. `residue` always reads the stored count plus one, modulo 2^16.
- R7: A loaded count of N yields N+1 transfers. `tc` is high only during the transfer made while the stored count is 0.
- R8: At terminal count with auto-reload off, the channel masks itself and `residue` then reads 0.
- R9: At terminal count with auto-reload on, the address and count return to their loaded start values and the channel stays unmasked.
- R10: `cfg_load` writes the start and current address, the count, the page and the auto-reload flag. The mask is unaffected, and a load takes precedence over a transfer in the same cycle.
- R11: A loaded count of 0xFFFF gives 65536 transfers before terminal count.
- R12: `mask_set` masks the channel and `mask_clr` unmasks it. `mask_set` wins when both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the start values |
| cfg_addr | input | 16 | Start address |
| cfg_count | input | 16 | Start count (transfers minus one) |
| cfg_page | input | 8 | Page value |
| cfg_autoinit | input | 1 | Auto-reload on terminal count |
| mask_set | input | 1 | Mask the channel |
| mask_clr | input | 1 | Unmask the channel |
| req | input | 1 | Channel request |
| ack | input | 1 | Transfer acknowledge |
| xfer_valid | output | 1 | A transfer takes place this cycle |
| phys_addr | output | 24 | Physical address of the current transfer |
| tc | output | 1 | Terminal count, high on the last transfer |
| masked | output | 1 | Channel mask state |
| residue | output | 16 | Stored count plus one |

## Verification
The bench starts a block at 0xFFFE so that it crosses the top of the window. A design that carried into the page, or that forgot to shift and drop page bit 0 in word units, would show a wrong upper address. It checks the exact length of a block, including the full 65536-transfer case, where an off-by-one count would end one transfer early or late. Auto-reload is run over several blocks, because a design that masked itself or resumed from the wrapped values would stop or drift. It also drives acknowledges while the channel is masked, while the request is low, and together with a load, because a design that let any of these advance would skip addresses.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic {
      XFER_BYTE = 1'b0,
      XFER_WORD = 1'b1
   } xfer_unit_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         reload,
   input  logic         adv,
   output logic [W-1:0] cur
);
   logic [W-1:0] base_q;
   logic [W-1:0] cur_q;

   if (W < 1) begin : g_bad_w
      $error("dma_addr_ctr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load) begin
         base_q <= load_val;
         cur_q  <= load_val;
      end else if (adv && reload) begin
         cur_q  <= base_q;
      end else if (adv) begin
         cur_q  <= cur_q + 1'b1;
      end
   end

   assign cur = cur_q;

   assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !reload) |=> (cur == $past(cur) + 1'b1));

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(cur));
endmodule

// File: rtl/dma_cnt_ctr.sv
module dma_cnt_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         reload,
   input  logic         adv,
   output logic         at_zero,
   output logic [W-1:0] residue
);
   logic [W-1:0] base_q;
   logic [W-1:0] cnt_q;

   if (W < 2) begin : g_bad_w
      $error("dma_cnt_ctr: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= load_val;
         cnt_q  <= load_val;
      end else if (adv && reload) begin
         cnt_q  <= base_q;
      end else if (adv) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign at_zero = (cnt_q == '0);
   assign residue = cnt_q + 1'b1;

   assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && !reload) |=> (residue == $past(residue) - 1'b1));
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
   import dma_chan_pkg::*;
#(
   parameter int         ADDR_W = 16,
   parameter int         PAGE_W = 8,
   parameter xfer_unit_e UNIT   = XFER_BYTE,
   localparam int        PHYS_W = ADDR_W + PAGE_W
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [ADDR_W-1:0] addr,
   output logic [PHYS_W-1:0] phys
);
   if (PAGE_W < 2) begin : g_bad_page
      $error("dma_phys_map: PAGE_W must be at least 2");
   end

   if (UNIT == XFER_WORD) begin : g_word
      assign phys = {page[PAGE_W-1:1], addr, 1'b0};
   end else begin : g_byte
      assign phys = {page, addr};
   end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
   import dma_chan_pkg::*;
#(
   parameter int         ADDR_W = 16,
   parameter int         CNT_W  = 16,
   parameter int         PAGE_W = 8,
   parameter xfer_unit_e UNIT   = XFER_BYTE,
   localparam int        PHYS_W = ADDR_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic [PAGE_W-1:0] cfg_page,
   input  logic              cfg_autoinit,
   input  logic              mask_set,
   input  logic              mask_clr,
   input  logic              req,
   input  logic              ack,
   output logic              xfer_valid,
   output logic [PHYS_W-1:0] phys_addr,
   output logic              tc,
   output logic              masked,
   output logic [CNT_W-1:0]  residue
);
   logic [PAGE_W-1:0] page_q;
   logic              auto_q;
   logic              mask_q;
   logic              xfer;
   logic              cnt_zero;
   logic              reload;
   logic [ADDR_W-1:0] addr_cur;

   assign xfer   = ack && req && !mask_q && !cfg_load;
   assign reload = cnt_zero && auto_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         auto_q <= 1'b0;
      end else if (cfg_load) begin
         page_q <= cfg_page;
         auto_q <= cfg_autoinit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (mask_set || (xfer && cnt_zero && !auto_q)) begin
         mask_q <= 1'b1;
      end else if (mask_clr) begin
         mask_q <= 1'b0;
      end
   end

   dma_addr_ctr #(.W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .load_val (cfg_addr),
      .reload   (reload),
      .adv      (xfer),
      .cur      (addr_cur)
   );

   dma_cnt_ctr #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_load),
      .load_val (cfg_count),
      .reload   (reload),
      .adv      (xfer),
      .at_zero  (cnt_zero),
      .residue  (residue)
   );

   dma_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .UNIT(UNIT)) u_map (
      .page (page_q),
      .addr (addr_cur),
      .phys (phys_addr)
   );

   assign xfer_valid = xfer;
   assign tc         = xfer && cnt_zero;
   assign masked     = mask_q;

   assert_tc_last_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (residue == CNT_W'(1)));

   assert_tc_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && !auto_q && !cfg_load) |=> (masked && residue == '0));

   assert_auto_stays_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tc && auto_q && !cfg_load && !mask_set) |=> !masked);

   assert_masked_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      masked |-> !xfer_valid);
endmodule

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;
   typedef struct packed {
      logic [23:0] pb;
      logic [23:0] pw;
      logic        t;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0, cfg_autoinit = 1'b0, mask_set = 1'b0, mask_clr = 1'b0;
   logic req = 1'b0, ack = 1'b0;
   logic [15:0] cfg_addr = '0, cfg_count = '0;
   logic [7:0]  cfg_page = '0;
   logic        xv_b, xv_w, tc_b, tc_w, mk_b, mk_w;
   logic [23:0] pa_b, pa_w;
   logic [15:0] rs_b, rs_w;

   int errors = 0;
   int checks = 0;
   exp_t sb[$];

   logic [15:0] m_addr = '0, m_cnt = '0, m_baddr = '0, m_bcnt = '0;
   logic [7:0]  m_page = '0;
   logic        m_auto = 1'b0, m_mask = 1'b1;

   always #2 clk = ~clk;

   dma_chan_engine #(.UNIT(dma_chan_pkg::XFER_BYTE)) u_dma_chan_engine (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
      .cfg_count(cfg_count), .cfg_page(cfg_page), .cfg_autoinit(cfg_autoinit),
      .mask_set(mask_set), .mask_clr(mask_clr), .req(req), .ack(ack),
      .xfer_valid(xv_b), .phys_addr(pa_b), .tc(tc_b), .masked(mk_b), .residue(rs_b));

   dma_chan_engine #(.UNIT(dma_chan_pkg::XFER_WORD)) u_dma_chan_engine_w (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
      .cfg_count(cfg_count), .cfg_page(cfg_page), .cfg_autoinit(cfg_autoinit),
      .mask_set(mask_set), .mask_clr(mask_clr), .req(req), .ack(ack),
      .xfer_valid(xv_w), .phys_addr(pa_w), .tc(tc_w), .masked(mk_w), .residue(rs_w));

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One clock of stimulus; the model advances when a transfer is expected.
   task automatic step(input logic r, input logic a);
      exp_t e;
      @(posedge clk); #1;
      cfg_load = 1'b0; mask_set = 1'b0; mask_clr = 1'b0;
      req = r; ack = a;
      if (r && a && !m_mask) begin
         e.pb = {m_page, m_addr};
         e.pw = {m_page[7:1], m_addr, 1'b0};
         e.t  = (m_cnt == 16'h0);
         sb.push_back(e);
         if (m_cnt == 16'h0 && m_auto) begin
            m_addr = m_baddr; m_cnt = m_bcnt;
         end else begin
            if (m_cnt == 16'h0) m_mask = 1'b1;
            m_addr = m_addr + 16'h1; m_cnt = m_cnt - 16'h1;
         end
      end
   endtask

   task automatic load(input logic [15:0] ad, input logic [15:0] cn, input logic [7:0] pg, input logic au);
      @(posedge clk); #1;
      req = 1'b0; ack = 1'b0; mask_set = 1'b0; mask_clr = 1'b0;
      cfg_load = 1'b1; cfg_addr = ad; cfg_count = cn; cfg_page = pg; cfg_autoinit = au;
      m_addr = ad; m_baddr = ad; m_cnt = cn; m_bcnt = cn; m_page = pg; m_auto = au;
   endtask

   task automatic unmask();
      @(posedge clk); #1;
      cfg_load = 1'b0; req = 1'b0; ack = 1'b0; mask_clr = 1'b1; mask_set = 1'b0;
      m_mask = 1'b0;
   endtask

   task automatic idle_check(input string tag);
      step(1'b0, 1'b0);
      @(negedge clk);
      chk(pa_b == {m_page, m_addr}, {tag, " byte addr"}, 32'(pa_b), 32'({m_page, m_addr}));
      chk(rs_b == m_cnt + 16'h1, {tag, " residue"}, 32'(rs_b), 32'(m_cnt + 16'h1));
      chk(mk_b == m_mask, {tag, " mask"}, 32'(mk_b), 32'(m_mask));
   endtask

   // Scoreboard monitor: compares every transfer against the queued item.
   always @(negedge clk) begin
      if (rst_n) begin
         if (xv_b !== xv_w) chk(1'b0, "R4 word instance valid mismatch", 32'(xv_w), 32'(xv_b));
         if (xv_b) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R2 unexpected transfer", 32'(pa_b), 32'h0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(pa_b == e.pb, "R3/R5 byte phys_addr", 32'(pa_b), 32'(e.pb));
               chk(pa_w == e.pw, "R4 word phys_addr", 32'(pa_w), 32'(e.pw));
               chk(tc_b == e.t && tc_w == e.t, "R7 tc", 32'(tc_b), 32'(e.t));
            end
         end else if (tc_b || tc_w) begin
            chk(1'b0, "R7 tc without transfer", 32'(tc_b), 32'h0);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(mk_b && mk_w, "R1 masked after reset", 32'(mk_b), 32'h1);
      chk(rs_b == 16'h1, "R1 residue after reset", 32'(rs_b), 32'h1);
      chk(!xv_b && !tc_b, "R1 idle after reset", 32'(xv_b), 32'h0);

      // R2: acknowledges while masked do nothing
      load(16'hFFFE, 16'h0003, 8'h35, 1'b0);
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      idle_check("R2 masked");

      // R3 R4 R5 R7 R8: four transfers crossing the window top
      unmask();
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      idle_check("R6 mid-block");
      step(1'b1, 1'b1);
      step(1'b1, 1'b1);
      idle_check("R8 after tc");
      chk(rs_b == 16'h0 && mk_b, "R8 residue zero and masked", 32'(rs_b), 32'h0);
      chk(pa_b == 24'h350002, "R5 wrap stays in page", 32'(pa_b), 32'h350002);

      // R2: request low and acknowledge low
      unmask();
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      idle_check("R2 no request");
      chk(!mk_b, "R12 mask_clr unmasks", 32'(mk_b), 32'h0);

      // R12: set beats clear
      @(posedge clk); #1; mask_set = 1'b1; mask_clr = 1'b1; m_mask = 1'b1;
      idle_check("R12 set wins");

      // R9: auto-reload over several blocks
      load(16'h1000, 16'h0001, 8'hA7, 1'b1);
      unmask();
      for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
      idle_check("R9 auto");
      chk(!mk_b && pa_b == 24'hA71001, "R9 still enabled after reloads", 32'(pa_b), 32'hA71001);

      // R10: load in the same cycle as an acknowledge wins
      @(posedge clk); #1;
      req = 1'b1; ack = 1'b1; cfg_load = 1'b1;
      cfg_addr = 16'h2222; cfg_count = 16'h0005; cfg_page = 8'h11; cfg_autoinit = 1'b0;
      m_addr = 16'h2222; m_baddr = 16'h2222; m_cnt = 16'h5; m_bcnt = 16'h5; m_page = 8'h11; m_auto = 1'b0;
      idle_check("R10 load priority");
      chk(rs_b == 16'h6, "R10 residue after load", 32'(rs_b), 32'h6);

      // R11: full 65536-transfer block
      load(16'h0000, 16'hFFFF, 8'h80, 1'b0);
      unmask();
      for (int i = 0; i < 65535; i++) step(1'b1, 1'b1);
      idle_check("R11 one left");
      chk(rs_b == 16'h1 && !mk_b, "R11 one transfer remains", 32'(rs_b), 32'h1);
      step(1'b1, 1'b1);
      idle_check("R11 done");
      chk(mk_b && pa_b == 24'h800000, "R11 ended and wrapped", 32'(pa_b), 32'h800000);

      repeat (2) @(negedge clk);
      chk(sb.size() == 0, "R7 all expected transfers seen", 32'(sb.size()), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule